// File: doc/BRIEF.md
# Capture/Compare PWM Timer Channel

This block is a single channel of a counter array. It does not own a counter: it watches a shared 18-bit time base, which supplies the count value plus one-cycle overflow and intermediate pulses. From these it drives one output pin in one of five operating modes: edge-aligned PWM, center-aligned PWM, n-bit PWM, a high-frequency square wave, or timer with input capture. A 2-bit action code decides what each event does to the pin: toggle, drive high, drive low, or leave it alone. Software reaches the channel through a simple 32-bit register bus with write strobe, address and combinational read data.

The compare value is double-buffered. A bus write to the update register stores the next value and moves a small state machine from `UPD_IDLE` to `UPD_PEND`. While in `UPD_PEND`, the next overflow pulse copies the stored value into the active compare register and returns the machine to `UPD_IDLE`. If a new update write lands in that same cycle, the machine stays in `UPD_PEND` so that the new value waits for the following overflow. The external capture input is synchronised through two flops and then edge-detected. An enabled edge in capture mode latches the current count into the compare register. Two interrupt levels, one for capture/compare and one for the intermediate event, are held until software clears them.

Top module: `ccp_channel`

## Requirements
- R1: After reset the pin, both interrupt outputs, the pending flag and every register read as 0. The mode is edge-aligned and the action is toggle.
- R2: Mode register at 0x00: action in bits 1:0, n-bit width in bits 5:2, mode in bits 10:8. Unused bits read 0, so writing all ones reads back 0x0000073F.
- R3: Control register at 0x10 is written directly. Offset 0x14 ORs the written ones into it and offset 0x18 clears the written ones. Bit 1 is the rising-capture enable, bit 2 the falling-capture enable, bit 8 the capture/compare interrupt enable and bit 11 the intermediate interrupt enable.
- R4: Action codes are 0 toggle, 1 drive high, 2 drive low and 3 keep. When several events fall in one cycle, the action is applied once. With no event and no control write, the pin holds.
- R5: Mode 0 (edge-aligned): events are a full 18-bit match between count and compare, and the overflow pulse.
- R6: Mode 1 (center-aligned): the only event is a full match, so a counter sweeping up and then down passes the compare value twice. Overflow has no effect on the pin.
- R7: Mode 2 (square wave): events are a full match and the intermediate pulse. Overflow has no effect.
- R8: Mode 4 (n-bit): a match compares only the low n bits, where n is the width field. A wrap event fires when the low n bits of the count are all zero.
- R9: Mode 3 (capture): the input passes through two synchronising flops. An enabled rising or falling edge latches the count into the compare register three clock edges after the input changes, and counts as a capture/compare event.
- R10: A write to 0x30 stores the update value and sets control bit 3. The next overflow copies it into the compare register at 0x20 and clears bit 3. A capture in the same cycle takes priority.
- R11: The capture/compare flag (control bit 16, output `irq_cc`) sets on a capture/compare event only while bit 8 is set. It holds until a 1 is written to bit 16 through 0x18.
- R12: The intermediate flag (control bit 17, output `irq_mid`) sets on an intermediate pulse only while bit 11 is set. It holds until a 1 is written to bit 17 through 0x18.
- R13: Mode codes 5 to 7 produce no events, and the pin holds.
- R14: Control bit 0 reads the pin level. Writing bit 0 (directly, or via set or clear) forces the pin, and this takes priority over events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tb_count | input | 18 | Shared time-base count |
| tb_ovf | input | 1 | Time-base overflow pulse |
| tb_mid | input | 1 | Time-base intermediate pulse |
| cap_in | input | 1 | Asynchronous capture input |
| ch_out | output | 1 | Channel output pin |
| irq_cc | output | 1 | Capture/compare interrupt level |
| irq_mid | output | 1 | Intermediate interrupt level |

## Verification
The assertions check the following on every cycle:
- the pending flag rising on an update write;
- the overflow-time copy of the update value and the clearing of the flag;
- capture latching the count;
- the interrupt flags being gated by their enables and set by their events;
- the pin holding when there is neither an event nor a control write, including in the reserved modes.

What counts as an event in each mode can only be shown by the bench's scenarios. These include the twice-per-period match of a center-aligned sweep, low-bit masking and wrap in n-bit mode, and the synchroniser latency.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;

    typedef enum logic [2:0] {
        MD_EDGE    = 3'd0,
        MD_CENTER  = 3'd1,
        MD_SQUARE  = 3'd2,
        MD_CAPTURE = 3'd3,
        MD_NBIT    = 3'd4
    } ccp_mode_e;

    typedef enum logic [1:0] {
        ACT_TOGGLE = 2'd0,
        ACT_HIGH   = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_KEEP   = 2'd3
    } ccp_act_e;

    typedef enum logic {
        UPD_IDLE = 1'b0,
        UPD_PEND = 1'b1
    } ccp_upd_e;

    // register byte offsets
    localparam int OFF_MODE = 'h00;
    localparam int OFF_CTL  = 'h10;
    localparam int OFF_SET  = 'h14;
    localparam int OFF_CLR  = 'h18;
    localparam int OFF_CMP  = 'h20;
    localparam int OFF_UPD  = 'h30;

    // mode register fields
    localparam int F_ACT_LO  = 0;
    localparam int F_NW_LO   = 2;
    localparam int F_MODE_LO = 8;

    // control register bits
    localparam int B_OUT   = 0;
    localparam int B_CAPP  = 1;
    localparam int B_CAPN  = 2;
    localparam int B_PEND  = 3;
    localparam int B_CCIE  = 8;
    localparam int B_MIDIE = 11;
    localparam int B_CCFL  = 16;
    localparam int B_MIDFL = 17;

endpackage

// File: rtl/ccp_insync.sv
`timescale 1ns/1ps
module ccp_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], din};
    end

    assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
    assign fall = ~shift_q[STAGES-1] & shift_q[STAGES];
endmodule

// File: rtl/ccp_match.sv
`timescale 1ns/1ps
module ccp_match
    import ccp_pkg::*;
#(
    parameter int CNT_W = 18,
    parameter int NW_W  = 4
) (
    input  logic [2:0]       mode_sel,
    input  logic [NW_W-1:0]  nbits,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             ovf,
    input  logic             mid,
    input  logic             rise,
    input  logic             fall,
    input  logic             pos_en,
    input  logic             neg_en,
    output logic             cc_ev,
    output logic             aux_ev,
    output logic             cap_fire
);
    logic [CNT_W-1:0] low_mask;
    logic             full_hit, low_hit, low_wrap, edge_hit;

    assign low_mask = ~({CNT_W{1'b1}} << nbits);
    assign full_hit = (count == cmp);
    assign low_hit  = ((count ^ cmp) & low_mask) == '0;
    assign low_wrap = (count & low_mask) == '0;
    assign edge_hit = (rise & pos_en) | (fall & neg_en);

    always_comb begin
        cc_ev    = 1'b0;
        aux_ev   = 1'b0;
        cap_fire = 1'b0;
        unique case (mode_sel)
            MD_EDGE: begin
                cc_ev  = full_hit;
                aux_ev = ovf;
            end
            MD_CENTER: begin
                cc_ev  = full_hit;
            end
            MD_SQUARE: begin
                cc_ev  = full_hit;
                aux_ev = mid;
            end
            MD_CAPTURE: begin
                cap_fire = edge_hit;
                cc_ev    = edge_hit;
            end
            MD_NBIT: begin
                cc_ev  = low_hit;
                aux_ev = low_wrap;
            end
            default: begin
                cc_ev  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ccp_outact.sv
`timescale 1ns/1ps
module ccp_outact
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] act,
    input  logic       ev,
    input  logic       sw_we,
    input  logic       sw_val,
    output logic       pin
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (sw_we) begin
            pin <= sw_val;
        end else if (ev) begin
            unique case (ccp_act_e'(act))
                ACT_TOGGLE: pin <= ~pin;
                ACT_HIGH:   pin <= 1'b1;
                ACT_LOW:    pin <= 1'b0;
                ACT_KEEP:   pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/ccp_channel.sv
`timescale 1ns/1ps
module ccp_channel
    import ccp_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int BUS_W       = 32,
    parameter int ADDR_W      = 8,
    parameter int NW_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_ovf,
    input  logic              tb_mid,
    input  logic              cap_in,
    output logic              ch_out,
    output logic              irq_cc,
    output logic              irq_mid
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);
    localparam logic [ADDR_W-1:0] A_UPD  = ADDR_W'(OFF_UPD);

    // configuration and status state
    logic [1:0]       act_q;
    logic [NW_W-1:0]  nw_q;
    logic [2:0]       mode_q;
    logic             capp_q, capn_q, ccie_q, midie_q;
    logic             ccfl_q, midfl_q;
    logic [CNT_W-1:0] cmp_q, upd_q;

    ccp_upd_e upd_state, upd_next;
    logic     upd_pend, upd_apply;

    logic wr_mode, wr_ctl, wr_set, wr_clr, wr_cmp, wr_upd;
    logic cap_rise, cap_fall, cc_ev, aux_ev, cap_fire;
    logic sw_out_we, sw_out_val;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign wr_mode = bus_we && (bus_addr == A_MODE);
    assign wr_ctl  = bus_we && (bus_addr == A_CTL);
    assign wr_set  = bus_we && (bus_addr == A_SET);
    assign wr_clr  = bus_we && (bus_addr == A_CLR);
    assign wr_cmp  = bus_we && (bus_addr == A_CMP);
    assign wr_upd  = bus_we && (bus_addr == A_UPD);

    // ---------------- sub-blocks ----------------
    ccp_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cap_in),
        .rise (cap_rise),
        .fall (cap_fall)
    );

    ccp_match #(.CNT_W(CNT_W), .NW_W(NW_W)) u_match (
        .mode_sel(mode_q),
        .nbits   (nw_q),
        .count   (tb_count),
        .cmp     (cmp_q),
        .ovf     (tb_ovf),
        .mid     (tb_mid),
        .rise    (cap_rise),
        .fall    (cap_fall),
        .pos_en  (capp_q),
        .neg_en  (capn_q),
        .cc_ev   (cc_ev),
        .aux_ev  (aux_ev),
        .cap_fire(cap_fire)
    );

    assign sw_out_we  = wr_ctl | ((wr_set | wr_clr) & bus_wdata[B_OUT]);
    assign sw_out_val = wr_ctl ? bus_wdata[B_OUT] : wr_set;

    ccp_outact u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act_q),
        .ev    (cc_ev | aux_ev),
        .sw_we (sw_out_we),
        .sw_val(sw_out_val),
        .pin   (ch_out)
    );

    // ---------------- update state machine ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_state <= UPD_IDLE;
        else        upd_state <= upd_next;
    end

    always_comb begin
        upd_next = upd_state;
        unique case (upd_state)
            UPD_IDLE: if (wr_upd)            upd_next = UPD_PEND;
            UPD_PEND: if (tb_ovf && !wr_upd) upd_next = UPD_IDLE;
        endcase
    end

    always_comb begin
        upd_pend  = (upd_state == UPD_PEND);
        upd_apply = upd_pend && tb_ovf;
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            nw_q   <= '0;
            mode_q <= '0;
        end else if (wr_mode) begin
            act_q  <= bus_wdata[F_ACT_LO +: 2];
            nw_q   <= bus_wdata[F_NW_LO +: NW_W];
            mode_q <= bus_wdata[F_MODE_LO +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capp_q  <= 1'b0;
            capn_q  <= 1'b0;
            ccie_q  <= 1'b0;
            midie_q <= 1'b0;
        end else if (wr_ctl) begin
            capp_q  <= bus_wdata[B_CAPP];
            capn_q  <= bus_wdata[B_CAPN];
            ccie_q  <= bus_wdata[B_CCIE];
            midie_q <= bus_wdata[B_MIDIE];
        end else if (wr_set) begin
            capp_q  <= capp_q  | bus_wdata[B_CAPP];
            capn_q  <= capn_q  | bus_wdata[B_CAPN];
            ccie_q  <= ccie_q  | bus_wdata[B_CCIE];
            midie_q <= midie_q | bus_wdata[B_MIDIE];
        end else if (wr_clr) begin
            capp_q  <= capp_q  & ~bus_wdata[B_CAPP];
            capn_q  <= capn_q  & ~bus_wdata[B_CAPN];
            ccie_q  <= ccie_q  & ~bus_wdata[B_CCIE];
            midie_q <= midie_q & ~bus_wdata[B_MIDIE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccfl_q  <= 1'b0;
            midfl_q <= 1'b0;
        end else begin
            if (cc_ev && ccie_q)                 ccfl_q  <= 1'b1;
            else if (wr_clr && bus_wdata[B_CCFL]) ccfl_q  <= 1'b0;
            if (tb_mid && midie_q)                midfl_q <= 1'b1;
            else if (wr_clr && bus_wdata[B_MIDFL]) midfl_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            upd_q <= '0;
        end else begin
            if (cap_fire)       cmp_q <= tb_count;
            else if (upd_apply) cmp_q <= upd_q;
            else if (wr_cmp)    cmp_q <= bus_wdata[CNT_W-1:0];
            if (wr_upd)         upd_q <= bus_wdata[CNT_W-1:0];
        end
    end

    assign irq_cc  = ccfl_q;
    assign irq_mid = midfl_q;

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE) begin
            bus_rdata[F_ACT_LO +: 2]     = act_q;
            bus_rdata[F_NW_LO +: NW_W]   = nw_q;
            bus_rdata[F_MODE_LO +: 3]    = mode_q;
        end else if (bus_addr == A_CTL || bus_addr == A_SET || bus_addr == A_CLR) begin
            bus_rdata[B_OUT]   = ch_out;
            bus_rdata[B_CAPP]  = capp_q;
            bus_rdata[B_CAPN]  = capn_q;
            bus_rdata[B_PEND]  = upd_pend;
            bus_rdata[B_CCIE]  = ccie_q;
            bus_rdata[B_MIDIE] = midie_q;
            bus_rdata[B_CCFL]  = ccfl_q;
            bus_rdata[B_MIDFL] = midfl_q;
        end else if (bus_addr == A_CMP) begin
            bus_rdata[CNT_W-1:0] = cmp_q;
        end else if (bus_addr == A_UPD) begin
            bus_rdata[CNT_W-1:0] = upd_q;
        end
    end
endmodule

// File: rtl/ccp_channel_chk.sv
`timescale 1ns/1ps
module ccp_channel_chk
    import ccp_pkg::*;
#(
    parameter int CNT_W  = 18,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  tb_count,
    input logic              tb_ovf,
    input logic              tb_mid,
    input logic              ch_out,
    input logic              irq_cc,
    input logic              irq_mid,
    input logic              pend,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [CNT_W-1:0]  upd_q,
    input logic              cc_ev,
    input logic              aux_ev,
    input logic              cap_fire,
    input logic              cc_ie,
    input logic              mid_ie,
    input logic [2:0]        mode_sel
);
    logic wr_upd, wr_ctl_any, clr_cc;

    assign wr_upd     = bus_we && (bus_addr == ADDR_W'(OFF_UPD));
    assign wr_ctl_any = bus_we && (bus_addr == ADDR_W'(OFF_CTL) ||
                                   bus_addr == ADDR_W'(OFF_SET) ||
                                   bus_addr == ADDR_W'(OFF_CLR));
    assign clr_cc     = bus_we && (bus_addr == ADDR_W'(OFF_CLR)) && bus_wdata[B_CCFL];

    p_pend_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_upd |=> pend) else $error("update write did not raise pending");

    p_apply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && tb_ovf && !cap_fire) |=> (cmp_q == $past(upd_q)))
        else $error("pending value not applied at overflow");

    p_apply_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && tb_ovf && !wr_upd) |=> !pend) else $error("pending flag stuck");

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cmp_q == $past(tb_count))) else $error("capture lost count");

    p_cc_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_ev && cc_ie) |=> irq_cc) else $error("cc flag not set");

    p_cc_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_cc && !(cc_ev && cc_ie)) |=> !irq_cc) else $error("cc flag set without cause");

    p_cc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cc && !clr_cc) |=> irq_cc) else $error("cc flag dropped");

    p_mid_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_mid && mid_ie) |=> irq_mid) else $error("mid flag not set");

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_ev && !aux_ev && !wr_ctl_any) |=> $stable(ch_out))
        else $error("pin moved without event");

    p_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel >= 3'd5 && !wr_ctl_any) |=> $stable(ch_out))
        else $error("pin moved in reserved mode");
endmodule

bind ccp_channel ccp_channel_chk #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .tb_count (tb_count),
    .tb_ovf   (tb_ovf),
    .tb_mid   (tb_mid),
    .ch_out   (ch_out),
    .irq_cc   (irq_cc),
    .irq_mid  (irq_mid),
    .pend     (upd_pend),
    .cmp_q    (cmp_q),
    .upd_q    (upd_q),
    .cc_ev    (cc_ev),
    .aux_ev   (aux_ev),
    .cap_fire (cap_fire),
    .cc_ie    (ccie_q),
    .mid_ie   (midie_q),
    .mode_sel (mode_q)
);

// File: tb/ccp_channel_test.sv
`timescale 1ns/1ps
module ccp_channel_test;
    localparam logic [17:0] PARK = 18'h3FFFF;
    localparam logic [7:0] A_MODE = 8'h00, A_CTL = 8'h10, A_SET = 8'h14,
                           A_CLR = 8'h18, A_CMP = 8'h20, A_UPD = 8'h30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [17:0] tb_count;
    logic        tb_ovf, tb_mid, cap_in;
    logic        ch_out, irq_cc, irq_mid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ccp_channel uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_count(tb_count),
        .tb_ovf(tb_ovf), .tb_mid(tb_mid), .cap_in(cap_in), .ch_out(ch_out),
        .irq_cc(irq_cc), .irq_mid(irq_mid)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input logic [17:0] c, input logic o, input logic m);
        tb_count = c; tb_ovf = o; tb_mid = m;
        step();
        tb_count = PARK; tb_ovf = 1'b0; tb_mid = 1'b0;
    endtask

    function automatic logic next_pin(input logic [1:0] a, input logic cur);
        case (a)
            2'd0:    return ~cur;
            2'd1:    return 1'b1;
            2'd2:    return 1'b0;
            default: return cur;
        endcase
    endfunction

    function automatic logic [31:0] pinw();
        return {31'b0, ch_out};
    endfunction

    initial begin
        logic [31:0] r;
        logic [1:0]  act;
        logic [17:0] cv;
        logic        exp_pin;
        int unsigned seed;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        tb_count = PARK; tb_ovf = 1'b0; tb_mid = 1'b0; cap_in = 1'b0;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin", pinw(), 0);
        chk("R1 irq", {30'b0, irq_cc, irq_mid}, 0);
        rd(A_MODE, r); chk("R1 mode", r, 0);
        rd(A_CTL, r);  chk("R1 ctl", r, 0);
        rd(A_CMP, r);  chk("R1 cmp", r, 0);
        rd(A_UPD, r);  chk("R1 upd", r, 0);

        // R2 mode register fields
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, r); chk("R2 mode readback", r, 32'h0000_073F);
        wr(A_MODE, 32'h0000_0003);

        // R3 control direct/set/clear, R14 pin via bit 0
        wr(A_CTL, 32'h0000_0906);
        rd(A_CTL, r); chk("R3 direct", r, 32'h0000_0906);
        wr(A_CLR, 32'h0000_0100);
        rd(A_CTL, r); chk("R3 clear alias", r, 32'h0000_0806);
        wr(A_SET, 32'h0000_0001);
        rd(A_CTL, r); chk("R3 set alias", r, 32'h0000_0807);
        chk("R14 pin forced high", pinw(), 1);
        wr(A_CLR, 32'h0000_0807);
        rd(A_CTL, r); chk("R14 ctl all clear", r, 0);
        chk("R14 pin forced low", pinw(), 0);

        // R4 directed action codes in edge mode
        wr(A_CMP, 32'd7);
        wr(A_MODE, 32'd1); cyc(18'd7, 1'b0, 1'b0); chk("R4 drive high", pinw(), 1);
        wr(A_MODE, 32'd2); cyc(18'd7, 1'b0, 1'b0); chk("R4 drive low", pinw(), 0);
        wr(A_SET, 32'd1);
        wr(A_MODE, 32'd3); cyc(18'd7, 1'b1, 1'b0); chk("R4 keep", pinw(), 1);
        wr(A_CMP, 32'd0); wr(A_MODE, 32'd0); wr(A_CLR, 32'd1);
        cyc(18'd0, 1'b1, 1'b0); chk("R4 match+ovf toggles once", pinw(), 1);

        // R5 edge-aligned, random compare and action
        for (int t = 0; t < 6; t++) begin
            act = 2'($urandom_range(0, 3));
            cv  = 18'($urandom_range(0, 63));
            wr(A_CMP, {14'b0, cv});
            wr(A_MODE, {30'b0, act});
            wr(A_CLR, 32'd1);
            exp_pin = 1'b0;
            for (int i = 0; i < 150; i++) begin
                logic [17:0] c;
                logic        o;
                c = 18'(i % 64);
                o = (c == 18'd0);
                cyc(c, o, 1'($urandom_range(0, 1)));
                if (c == cv || o) exp_pin = next_pin(act, exp_pin);
                chk("R5 edge-aligned pin", pinw(), {31'b0, exp_pin});
            end
        end

        // R6 center-aligned
        wr(A_CMP, 32'd5); wr(A_MODE, 32'h100); wr(A_CLR, 32'd1);
        cyc(18'd0, 1'b1, 1'b0); chk("R6 ovf ignored", pinw(), 0);
        for (int i = 1; i < 10; i++) cyc(18'(i), 1'b0, 1'b0);
        chk("R6 up match", pinw(), 1);
        for (int i = 8; i >= 0; i--) cyc(18'(i), 1'b0, 1'b0);
        chk("R6 down match", pinw(), 0);

        // R7 square wave
        wr(A_CMP, 32'd3); wr(A_MODE, 32'h200); wr(A_CLR, 32'd1);
        cyc(18'd3, 1'b0, 1'b0); chk("R7 match", pinw(), 1);
        cyc(18'd4, 1'b1, 1'b0); chk("R7 ovf ignored", pinw(), 1);
        cyc(18'd4, 1'b0, 1'b1); chk("R7 intermediate", pinw(), 0);

        // R8 n-bit mode, width 3
        wr(A_CMP, 32'h15); wr(A_MODE, 32'h40C); wr(A_CLR, 32'd1);
        cyc(18'h0D, 1'b0, 1'b0); chk("R8 low-bit match", pinw(), 1);
        cyc(18'h0E, 1'b0, 1'b0); chk("R8 no event", pinw(), 1);
        cyc(18'h08, 1'b0, 1'b0); chk("R8 wrap", pinw(), 0);
        cyc(18'h15, 1'b0, 1'b0); chk("R8 full match", pinw(), 1);

        // R13 reserved mode
        wr(A_MODE, 32'h600);
        cyc(18'h15, 1'b1, 1'b1); chk("R13 reserved holds", pinw(), 1);
        wr(A_CLR, 32'd1);
        cyc(18'h15, 1'b1, 1'b1); chk("R13 reserved holds low", pinw(), 0);

        // R9 capture
        wr(A_MODE, 32'h300); wr(A_SET, 32'h2);
        tb_count = 18'h1234; cap_in = 1'b1;
        step(); step();
        rd(A_CMP, r); chk("R9 not yet captured", r, 32'h15);
        step();
        rd(A_CMP, r); chk("R9 rising capture", r, 32'h1234);
        chk("R9 capture event toggles", pinw(), 1);
        tb_count = 18'h2222; cap_in = 1'b0;
        repeat (4) step();
        rd(A_CMP, r); chk("R9 falling disabled", r, 32'h1234);
        wr(A_SET, 32'h4);
        tb_count = 18'h0444; cap_in = 1'b1;
        repeat (4) step();
        rd(A_CMP, r); chk("R9 both edges rise", r, 32'h0444);
        tb_count = 18'h0555; cap_in = 1'b0;
        repeat (4) step();
        rd(A_CMP, r); chk("R9 both edges fall", r, 32'h0555);
        chk("R9 pin after two more captures", pinw(), 1);
        tb_count = PARK;

        // R10 double-buffered update
        wr(A_UPD, 32'h77);
        rd(A_CTL, r); chk("R10 pending set", r & 32'h8, 32'h8);
        rd(A_CMP, r); chk("R10 compare unchanged", r, 32'h0555);
        cyc(PARK, 1'b0, 1'b0); cyc(PARK, 1'b0, 1'b0);
        rd(A_CTL, r); chk("R10 still pending", r & 32'h8, 32'h8);
        cyc(PARK, 1'b1, 1'b0);
        rd(A_CMP, r); chk("R10 applied at overflow", r, 32'h77);
        rd(A_CTL, r); chk("R10 pending cleared", r & 32'h8, 0);

        // R11 capture/compare interrupt
        wr(A_CLR, 32'h6); wr(A_MODE, 32'h3); wr(A_CMP, 32'h20);
        cyc(18'h20, 1'b0, 1'b0); chk("R11 disabled no flag", {31'b0, irq_cc}, 0);
        wr(A_SET, 32'h100);
        cyc(18'h20, 1'b0, 1'b0); chk("R11 flag set", {31'b0, irq_cc}, 1);
        repeat (3) step();
        rd(A_CTL, r); chk("R11 flag held", r & 32'h1_0100, 32'h1_0100);
        wr(A_CLR, 32'h1_0000);
        rd(A_CTL, r); chk("R11 flag cleared, enable kept", r & 32'h1_0100, 32'h100);

        // R12 intermediate interrupt
        cyc(PARK, 1'b0, 1'b1); chk("R12 disabled no flag", {31'b0, irq_mid}, 0);
        wr(A_SET, 32'h800);
        cyc(PARK, 1'b0, 1'b1); chk("R12 flag set", {31'b0, irq_mid}, 1);
        step();
        rd(A_CTL, r); chk("R12 flag held", r & 32'h2_0000, 32'h2_0000);
        wr(A_CLR, 32'h2_0000);
        chk("R12 flag cleared", {31'b0, irq_mid}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule